// File: doc/BRIEF.md
# Shared Page Translation Map

This block converts the 24-bit addresses of a network controller into addresses within a small board memory, using a page map that software can write. Each address is split into a page offset, a map index and a top nibble. The offset passes through unchanged. The index selects one 16-bit map entry. The top nibble is discarded. The selected entry supplies a physical frame number, a per-page byte-order flag and a flag that places the page either in on-board memory or behind an expansion bus.

The host keeps the map through a single entry port, which does one read or one write per cycle. Host memory accesses are translated through the same map as controller accesses. For this reason the block has two identical lookup channels, one for the controller and one for the host. Both channels read the shared table in the same cycle.

Each lookup channel carries a 16-bit data word next to its address. The channel swaps the two bytes of that word when the page is stored in controller (little-endian) order. A frame number at or beyond the end of the physical memory is not wrapped. It raises an out-of-range flag instead.

Top module: `pmap_xlate`

## Requirements
- R1: A lookup request in one cycle produces its acknowledge, and all of its result fields, in the next cycle. Cycles without a request produce no acknowledge, and the acknowledge is low out of reset.
- R2: Address bits 19:10 select the map entry. Bits 23:20 have no effect on any result.
- R3: Address bits 9:0 appear unchanged in bits 9:0 of the 18-bit physical address.
- R4: When the frame field (entry bits 11:0) is below 256, physical address bits 17:10 equal bits 7:0 of that field.
- R5: When the frame field is 256 or more, the out-of-range output is 1 and the physical address is 0. A frame field of 255 is in range.
- R6: The byte-order output equals entry bit 15 (1 = host big-endian, 0 = controller little-endian). The bank output equals entry bit 13 (1 = expansion bus, 0 = on-board).
- R7: The data output is the request's data word with its two bytes exchanged when entry bit 15 is 0, and the word unchanged when bit 15 is 1.
- R8: A map write is seen by every lookup presented in the following cycle or later. A lookup presented in the same cycle as the write sees the old entry.
- R9: A map read returns the stored 16-bit entry, all bits unchanged, one cycle later, with a read-valid pulse in that cycle.
- R10: The controller and host channels translate through the same table. Requests to the same index in the same cycle give identical order, bank and range results.
- R11: Address 0xFFFFF4 is translated through the last entry (1023), with page offset 0x3F4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_en | input | 1 | Map port operation enable |
| map_we | input | 1 | 1 = write entry, 0 = read entry |
| map_idx | input | 10 | Map entry index |
| map_wdata | input | 16 | Entry value to write |
| map_rdata | output | 16 | Entry read data |
| map_rvalid | output | 1 | Read data valid |
| ctl_req | input | 1 | Controller lookup request |
| ctl_addr | input | 24 | Controller address |
| ctl_data | input | 16 | Controller data word |
| ctl_ack | output | 1 | Controller result valid |
| ctl_phys | output | 18 | Controller physical address |
| ctl_order | output | 1 | Page byte order |
| ctl_bank | output | 1 | Page memory bank |
| ctl_oor | output | 1 | Frame out of range |
| ctl_data_out | output | 16 | Order-corrected data word |
| hst_req | input | 1 | Host lookup request |
| hst_addr | input | 24 | Host address |
| hst_data | input | 16 | Host data word |
| hst_ack | output | 1 | Host result valid |
| hst_phys | output | 18 | Host physical address |
| hst_order | output | 1 | Page byte order |
| hst_bank | output | 1 | Page memory bank |
| hst_oor | output | 1 | Frame out of range |
| hst_data_out | output | 16 | Order-corrected data word |

## Verification
The assertions assume that the map port never reads and writes in the same cycle. The single write-enable bit guarantees this.

The read-back check also assumes that the map port is idle during reset, so that nothing it sees two cycles back comes from a request made before reset. The stimulus holds every enable and request low throughout reset. It fills all 1024 entries before it issues any lookup, so no result depends on an unwritten entry.

// File: rtl/pmap_pkg.sv
package pmap_pkg;

   typedef enum logic {
      ORDER_LITTLE = 1'b0,
      ORDER_BIG    = 1'b1
   } byte_order_e;

   typedef enum logic {
      BANK_ONBOARD   = 1'b0,
      BANK_EXPANSION = 1'b1
   } mem_bank_e;

endpackage

// File: rtl/pmap_table.sv
// Page-map storage: one write port and N_RD registered read ports.
module pmap_table #(
   parameter int IDX_W   = 10,
   parameter int ENTRY_W = 16,
   parameter int N_RD    = 3,
   localparam int DEPTH  = 1 << IDX_W
) (
   input  logic               clk,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic [IDX_W-1:0]   rd_idx  [N_RD],
   output logic [ENTRY_W-1:0] rd_data [N_RD]
);

   if (N_RD < 1) begin : g_bad_rd
      $error("pmap_table: N_RD must be at least 1");
   end

   logic [ENTRY_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
   end

   // Reads sample the array before this edge's write lands.
   always_ff @(posedge clk) begin
      for (int r = 0; r < N_RD; r++) begin
         rd_data[r] <= mem[rd_idx[r]];
      end
   end

endmodule

// File: rtl/pmap_decode.sv
// Turns one map entry and a page offset into the translation result.
module pmap_decode
   import pmap_pkg::*;
#(
   parameter int ENTRY_W   = 16,
   parameter int FIELD_W   = 12,
   parameter int N_FRAMES  = 256,
   parameter int OFF_W     = 10,
   parameter int ORDER_POS = 15,
   parameter int BANK_POS  = 13,
   localparam int FRAME_W  = $clog2(N_FRAMES),
   localparam int PHYS_W   = FRAME_W + OFF_W
) (
   input  logic [ENTRY_W-1:0] entry,
   input  logic [OFF_W-1:0]   offset,
   output logic [PHYS_W-1:0]  phys,
   output byte_order_e        order,
   output mem_bank_e          bank,
   output logic               oor
);

   if (FIELD_W < FRAME_W || FIELD_W > ENTRY_W) begin : g_bad_field
      $error("pmap_decode: frame field width inconsistent");
   end
   if (ORDER_POS >= ENTRY_W || BANK_POS >= ENTRY_W) begin : g_bad_pos
      $error("pmap_decode: flag bit outside entry");
   end
   if (ORDER_POS < FIELD_W || BANK_POS < FIELD_W) begin : g_bad_overlap
      $error("pmap_decode: flag bit overlaps frame field");
   end

   logic [FIELD_W-1:0] frame;
   logic               unused_entry;

   assign frame        = entry[FIELD_W-1:0];
   assign unused_entry = ^entry;

   always_comb begin
      oor   = (int'(frame) >= N_FRAMES);
      phys  = oor ? '0 : {frame[FRAME_W-1:0], offset};
      order = byte_order_e'(entry[ORDER_POS]);
      bank  = mem_bank_e'(entry[BANK_POS]);
   end

endmodule

// File: rtl/pmap_swap.sv
// Byte reversal of a data word, present or bypassed by parameter.
module pmap_swap #(
   parameter int DATA_W  = 16,
   parameter bit SWAP_EN = 1'b1
) (
   input  logic              swap,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("pmap_swap: DATA_W must be whole bytes");
   end

   if (SWAP_EN) begin : g_swap
      localparam int NB = DATA_W / 8;
      logic [DATA_W-1:0] rev;
      always_comb begin
         for (int b = 0; b < NB; b++) begin
            rev[8*b +: 8] = din[8*(NB-1-b) +: 8];
         end
      end
      assign dout = swap ? rev : din;
   end else begin : g_pass
      logic unused_swap;
      assign unused_swap = swap;
      assign dout        = din;
   end

endmodule

// File: rtl/pmap_chan.sv
// One lookup channel: request pipeline register, decode and data order.
module pmap_chan
   import pmap_pkg::*;
#(
   parameter int ENTRY_W   = 16,
   parameter int FIELD_W   = 12,
   parameter int N_FRAMES  = 256,
   parameter int OFF_W     = 10,
   parameter int ORDER_POS = 15,
   parameter int BANK_POS  = 13,
   parameter int DATA_W    = 16,
   parameter bit SWAP_EN   = 1'b1,
   localparam int FRAME_W  = $clog2(N_FRAMES),
   localparam int PHYS_W   = FRAME_W + OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic [OFF_W-1:0]   offset,
   input  logic [DATA_W-1:0]  data,
   input  logic [ENTRY_W-1:0] entry,
   output logic               ack,
   output logic [PHYS_W-1:0]  phys,
   output byte_order_e        order,
   output mem_bank_e          bank,
   output logic               oor,
   output logic [DATA_W-1:0]  data_out
);

   logic [OFF_W-1:0]  off_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack    <= 1'b0;
         off_q  <= '0;
         data_q <= '0;
      end else begin
         ack    <= req;
         off_q  <= offset;
         data_q <= data;
      end
   end

   pmap_decode #(
      .ENTRY_W  (ENTRY_W),
      .FIELD_W  (FIELD_W),
      .N_FRAMES (N_FRAMES),
      .OFF_W    (OFF_W),
      .ORDER_POS(ORDER_POS),
      .BANK_POS (BANK_POS)
   ) u_dec (
      .entry (entry),
      .offset(off_q),
      .phys  (phys),
      .order (order),
      .bank  (bank),
      .oor   (oor)
   );

   pmap_swap #(
      .DATA_W (DATA_W),
      .SWAP_EN(SWAP_EN)
   ) u_swap (
      .swap(order == ORDER_LITTLE),
      .din (data_q),
      .dout(data_out)
   );

   AST_ACK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> ack); // R1
   AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !ack); // R1
   AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> (oor || phys[OFF_W-1:0] == $past(offset))); // R3

   if (SWAP_EN) begin : g_swap_chk
      AST_BIG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         req |=> (order != ORDER_BIG || data_out == $past(data))); // R7
      AST_LITTLE_SWAPPED: assert property (@(posedge clk) disable iff (!rst_n)
         req |=> (order != ORDER_LITTLE
                  || data_out[7:0] == $past(data[DATA_W-1 -: 8]))); // R7
   end

endmodule

// File: rtl/pmap_xlate.sv
// Top: shared page map with a host entry port and two lookup channels.
module pmap_xlate
   import pmap_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int OFF_W     = 10,
   parameter int IDX_W     = 10,
   parameter int ENTRY_W   = 16,
   parameter int FIELD_W   = 12,
   parameter int N_FRAMES  = 256,
   parameter int ORDER_POS = 15,
   parameter int BANK_POS  = 13,
   parameter int DATA_W    = 16,
   parameter bit SWAP_EN   = 1'b1,
   localparam int FRAME_W  = $clog2(N_FRAMES),
   localparam int PHYS_W   = FRAME_W + OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               map_en,
   input  logic               map_we,
   input  logic [IDX_W-1:0]   map_idx,
   input  logic [ENTRY_W-1:0] map_wdata,
   output logic [ENTRY_W-1:0] map_rdata,
   output logic               map_rvalid,
   input  logic               ctl_req,
   input  logic [ADDR_W-1:0]  ctl_addr,
   input  logic [DATA_W-1:0]  ctl_data,
   output logic               ctl_ack,
   output logic [PHYS_W-1:0]  ctl_phys,
   output logic               ctl_order,
   output logic               ctl_bank,
   output logic               ctl_oor,
   output logic [DATA_W-1:0]  ctl_data_out,
   input  logic               hst_req,
   input  logic [ADDR_W-1:0]  hst_addr,
   input  logic [DATA_W-1:0]  hst_data,
   output logic               hst_ack,
   output logic [PHYS_W-1:0]  hst_phys,
   output logic               hst_order,
   output logic               hst_bank,
   output logic               hst_oor,
   output logic [DATA_W-1:0]  hst_data_out
);

   localparam int N_CH   = 2;
   localparam int RD_MAP = N_CH;
   localparam int HI_W   = ADDR_W - OFF_W - IDX_W;

   if (HI_W < 1) begin : g_bad_split
      $error("pmap_xlate: offset plus index must leave discarded top bits");
   end

   logic [ADDR_W-1:0]  ch_addr  [N_CH];
   logic [N_CH-1:0]    ch_req;
   logic [DATA_W-1:0]  ch_data  [N_CH];
   logic [N_CH-1:0]    ch_ack;
   logic [PHYS_W-1:0]  ch_phys  [N_CH];
   byte_order_e        ch_order [N_CH];
   mem_bank_e          ch_bank  [N_CH];
   logic [N_CH-1:0]    ch_oor;
   logic [DATA_W-1:0]  ch_dout  [N_CH];
   logic [IDX_W-1:0]   rd_idx   [N_CH+1];
   logic [ENTRY_W-1:0] rd_data  [N_CH+1];
   logic               unused_hi;

   assign ch_addr[0] = ctl_addr;
   assign ch_addr[1] = hst_addr;
   assign ch_req     = {hst_req, ctl_req};
   assign ch_data[0] = ctl_data;
   assign ch_data[1] = hst_data;
   assign unused_hi  = ^{ctl_addr[ADDR_W-1 -: HI_W], hst_addr[ADDR_W-1 -: HI_W]};

   assign rd_idx[RD_MAP] = map_idx;

   pmap_table #(
      .IDX_W  (IDX_W),
      .ENTRY_W(ENTRY_W),
      .N_RD   (N_CH + 1)
   ) u_table (
      .clk    (clk),
      .wr_en  (map_en && map_we),
      .wr_idx (map_idx),
      .wr_data(map_wdata),
      .rd_idx (rd_idx),
      .rd_data(rd_data)
   );

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      assign rd_idx[g] = ch_addr[g][OFF_W +: IDX_W];

      pmap_chan #(
         .ENTRY_W  (ENTRY_W),
         .FIELD_W  (FIELD_W),
         .N_FRAMES (N_FRAMES),
         .OFF_W    (OFF_W),
         .ORDER_POS(ORDER_POS),
         .BANK_POS (BANK_POS),
         .DATA_W   (DATA_W),
         .SWAP_EN  (SWAP_EN)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .req     (ch_req[g]),
         .offset  (ch_addr[g][OFF_W-1:0]),
         .data    (ch_data[g]),
         .entry   (rd_data[g]),
         .ack     (ch_ack[g]),
         .phys    (ch_phys[g]),
         .order   (ch_order[g]),
         .bank    (ch_bank[g]),
         .oor     (ch_oor[g]),
         .data_out(ch_dout[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) map_rvalid <= 1'b0;
      else        map_rvalid <= map_en && !map_we;
   end
   assign map_rdata = rd_data[RD_MAP];

   assign ctl_ack      = ch_ack[0];
   assign ctl_phys     = ch_phys[0];
   assign ctl_order    = ch_order[0];
   assign ctl_bank     = ch_bank[0];
   assign ctl_oor      = ch_oor[0];
   assign ctl_data_out = ch_dout[0];
   assign hst_ack      = ch_ack[1];
   assign hst_phys     = ch_phys[1];
   assign hst_order    = ch_order[1];
   assign hst_bank     = ch_bank[1];
   assign hst_oor      = ch_oor[1];
   assign hst_data_out = ch_dout[1];

   AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (map_en && !map_we) |=> map_rvalid); // R9
   AST_RD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (map_rvalid && $past(map_en && map_we, 2)
       && $past(map_idx, 2) == $past(map_idx))
      |-> map_rdata == $past(map_wdata, 2)); // R9
   AST_SHARED_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_ack && hst_ack
       && $past(ctl_addr[OFF_W +: IDX_W]) == $past(hst_addr[OFF_W +: IDX_W]))
      |-> (ctl_order == hst_order && ctl_bank == hst_bank
           && ctl_oor == hst_oor)); // R10

endmodule

// File: tb/pmap_xlate_test.sv
`timescale 1ns/1ps
module pmap_xlate_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        map_en, map_we;
   logic [9:0]  map_idx;
   logic [15:0] map_wdata, map_rdata;
   logic        map_rvalid;
   logic        ctl_req, hst_req;
   logic [23:0] ctl_addr, hst_addr;
   logic [15:0] ctl_data, hst_data;
   logic        ctl_ack, hst_ack, ctl_order, hst_order, ctl_bank, hst_bank, ctl_oor, hst_oor;
   logic [17:0] ctl_phys, hst_phys;
   logic [15:0] ctl_data_out, hst_data_out;

   always #2 clk = ~clk;

   pmap_xlate uut (
      .clk(clk), .rst_n(rst_n),
      .map_en(map_en), .map_we(map_we), .map_idx(map_idx),
      .map_wdata(map_wdata), .map_rdata(map_rdata), .map_rvalid(map_rvalid),
      .ctl_req(ctl_req), .ctl_addr(ctl_addr), .ctl_data(ctl_data),
      .ctl_ack(ctl_ack), .ctl_phys(ctl_phys), .ctl_order(ctl_order),
      .ctl_bank(ctl_bank), .ctl_oor(ctl_oor), .ctl_data_out(ctl_data_out),
      .hst_req(hst_req), .hst_addr(hst_addr), .hst_data(hst_data),
      .hst_ack(hst_ack), .hst_phys(hst_phys), .hst_order(hst_order),
      .hst_bank(hst_bank), .hst_oor(hst_oor), .hst_data_out(hst_data_out)
   );

   int n_chk  = 0;
   int n_fail = 0;

   logic [15:0] mref [1024];
   bit          e_ack  [2];
   bit          e_oor  [2];
   bit          e_ord  [2];
   bit          e_bank [2];
   logic [17:0] e_phys [2];
   logic [15:0] e_dat  [2];
   bit          e_rv;
   logic [15:0] e_rd;

   logic        a_ack  [2];
   logic        a_oor  [2];
   logic        a_ord  [2];
   logic        a_bank [2];
   logic [17:0] a_phys [2];
   logic [15:0] a_dat  [2];
   assign a_ack[0]  = ctl_ack;   assign a_ack[1]  = hst_ack;
   assign a_oor[0]  = ctl_oor;   assign a_oor[1]  = hst_oor;
   assign a_ord[0]  = ctl_order; assign a_ord[1]  = hst_order;
   assign a_bank[0] = ctl_bank;  assign a_bank[1] = hst_bank;
   assign a_phys[0] = ctl_phys;  assign a_phys[1] = hst_phys;
   assign a_dat[0]  = ctl_data_out; assign a_dat[1] = hst_data_out;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic void predict(int ch, bit rq, logic [23:0] a, logic [15:0] d);
      logic [15:0] e;
      e           = mref[a[19:10]];
      e_ack[ch]   = rq;
      e_oor[ch]   = (e[11:0] >= 12'd256);
      e_phys[ch]  = e_oor[ch] ? 18'd0 : {e[7:0], a[9:0]};
      e_ord[ch]   = e[15];
      e_bank[ch]  = e[13];
      e_dat[ch]   = e[15] ? d : {d[7:0], d[15:8]};
   endfunction

   // One clock: inputs were driven after the previous falling edge.
   task automatic step();
      @(posedge clk);
      #1;
      predict(0, ctl_req, ctl_addr, ctl_data);
      predict(1, hst_req, hst_addr, hst_data);
      e_rv = map_en && !map_we;
      if (e_rv) e_rd = mref[map_idx];
      if (map_en && map_we) mref[map_idx] = map_wdata;
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
         chk("R1 ack", 32'(a_ack[c]), 32'(e_ack[c]));
         if (e_ack[c]) begin
            chk("R5 oor", 32'(a_oor[c]), 32'(e_oor[c]));
            if (!e_oor[c]) begin
               chk("R3 offset", 32'(a_phys[c][9:0]), 32'(e_phys[c][9:0]));
               chk("R4 frame", 32'(a_phys[c][17:10]), 32'(e_phys[c][17:10]));
            end else begin
               chk("R5 phys zero", 32'(a_phys[c]), 32'd0);
            end
            chk("R6 order", 32'(a_ord[c]), 32'(e_ord[c]));
            chk("R6 bank", 32'(a_bank[c]), 32'(e_bank[c]));
            chk("R7 data", 32'(a_dat[c]), 32'(e_dat[c]));
         end
      end
      chk("R9 rvalid", 32'(map_rvalid), 32'(e_rv));
      if (e_rv) chk("R9 rdata", 32'(map_rdata), 32'(e_rd));
   endtask

   task automatic idle();
      map_en = 0; map_we = 0; ctl_req = 0; hst_req = 0;
   endtask

   function automatic logic [15:0] fill_val(int i);
      int fr;
      fr = (i % 7 == 0) ? 256 + (i % 3000) : (i * 37 + 5) % 256;
      return {i[0], 1'b0, i[1], 1'b0, 12'(fr)};
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      summary();
   end

   initial begin
      logic [17:0] old_phys;
      for (int i = 0; i < 1024; i++) mref[i] = '0;
      rst_n = 0; idle();
      map_idx = 0; map_wdata = 0;
      ctl_addr = 0; hst_addr = 0; ctl_data = 0; hst_data = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 reset ack", 32'({ctl_ack, hst_ack}), 32'd0);
      chk("R9 reset rvalid", 32'(map_rvalid), 32'd0);

      // fill the whole map
      for (int i = 0; i < 1024; i++) begin
         map_en = 1; map_we = 1; map_idx = 10'(i); map_wdata = fill_val(i);
         step();
      end
      // read back a few entries, all bits intact (R9)
      for (int i = 0; i < 1024; i += 97) begin
         map_en = 1; map_we = 0; map_idx = 10'(i);
         step();
      end
      idle();

      // R11 / R2: top of space through the last entry, top nibble discarded
      map_en = 1; map_we = 1; map_idx = 10'd1023; map_wdata = 16'h80A5;
      step();
      idle();
      ctl_req = 1; ctl_addr = 24'hFFFFF4; ctl_data = 16'hBEEF;
      hst_req = 1; hst_addr = 24'h0FFFF4; hst_data = 16'hBEEF;
      step();
      chk("R11 last entry", 32'(ctl_phys), 32'({8'hA5, 10'h3F4}));
      chk("R2 upper ignored", 32'(hst_phys), 32'(ctl_phys));
      chk("R2 upper ignored data", 32'(hst_data_out), 32'(ctl_data_out));
      idle();

      // R8: same-cycle lookup sees old entry, next cycle sees new
      old_phys = (mref[5][11:0] >= 12'd256) ? 18'd0 : {mref[5][7:0], 10'h000};
      map_en = 1; map_we = 1; map_idx = 10'd5; map_wdata = 16'h80FF;
      ctl_req = 1; ctl_addr = 24'h001400; ctl_data = 16'h1234;
      step();
      chk("R8 old entry same cycle", 32'(ctl_phys), 32'(old_phys));
      map_en = 0;
      step();
      chk("R8 new entry", 32'(ctl_phys), 32'({8'hFF, 10'h000}));
      chk("R5 frame 255 in range", 32'(ctl_oor), 32'd0);
      chk("R7 big no swap", 32'(ctl_data_out), 32'h1234);
      idle();

      // R5/R6/R7: frame 256, little-endian, expansion bus
      map_en = 1; map_we = 1; map_idx = 10'd6; map_wdata = 16'h2100;
      step();
      idle();
      ctl_req = 1; ctl_addr = 24'h001BFF; ctl_data = 16'h1234;
      step();
      chk("R5 frame 256 oor", 32'(ctl_oor), 32'd1);
      chk("R5 phys zero", 32'(ctl_phys), 32'd0);
      chk("R6 bank expansion", 32'(ctl_bank), 32'd1);
      chk("R6 order little", 32'(ctl_order), 32'd0);
      chk("R7 swapped", 32'(ctl_data_out), 32'h3412);
      idle();

      // R10: both channels same index same cycle
      ctl_req = 1; ctl_addr = 24'h301800; ctl_data = 16'hA1B2;
      hst_req = 1; hst_addr = 24'h0019C3; hst_data = 16'h0F0E;
      step();
      chk("R10 order shared", 32'(hst_order), 32'(ctl_order));
      chk("R10 bank shared", 32'(hst_bank), 32'(ctl_bank));
      chk("R10 oor shared", 32'(hst_oor), 32'(ctl_oor));
      idle();

      // mixed traffic compared every clock against the model
      for (int n = 0; n < 3000; n++) begin
         int op;
         ctl_req  = ($urandom % 4) != 0;
         hst_req  = ($urandom % 3) != 0;
         ctl_addr = 24'($urandom);
         hst_addr = (n % 5 == 0) ? {4'($urandom), ctl_addr[19:0]} : 24'($urandom);
         ctl_data = 16'($urandom);
         hst_data = 16'($urandom);
         op = $urandom % 8;
         map_en    = (op < 2);
         map_we    = (op == 0);
         map_idx   = 10'($urandom);
         map_wdata = 16'($urandom);
         step();
      end
      idle();
      step();
      summary();
   end

endmodule